// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs a control word, a source address, a destination address and a byte count through a small word-indexed register port, then sets a start bit. The channel then moves the data as a sequence of beats. Each beat is one read from the source over a memory-style master port, followed by one write of the same data to the destination.

Each side of the copy is one of two kinds. It can be memory, whose address normally advances by the size of each beat. It can be a peripheral, selected by a nonzero slot number; a beat that touches a peripheral waits for that slot's request line and answers it with a one-cycle acknowledge. The channel supports three beat widths and two request disciplines (per beat, or once per group of eight beats). An auto-reload mode runs the same buffer in a loop and reports when each pass is half done and when it is fully done.

Register word indices: 0 control, 1 start, 2 source address, 3 destination address, 4 byte count, 5 remaining bytes (read only).

Top module: `dmac_channel`

## Requirements
- R1: After reset the start register and the remaining register both read 0, no memory request is issued, and both event outputs are low.
- R2: Each beat reads the current source address, then writes the returned read data to the current destination address. In memory-to-memory mode both addresses advance by the beat size after every beat.
- R3: Control bits 21:20 set the beat width. 0 gives 4 bytes, 1 gives 2 bytes, and 2 or 3 give 1 byte. `mem_bytes` shows the bytes of the current beat. When fewer bytes than the width remain, the last beat carries only the bytes that are left.
- R4: Control bit 7 holds the source address fixed and control bit 15 holds the destination address fixed.
- R5: Control bits 5:0 give the source type and bits 13:8 give the destination type. 0 means memory. A nonzero value N is a peripheral slot: the beat does not start while `per_req[N]` is low, and `per_ack[N]` pulses for exactly one cycle, in the cycle the beat's write is accepted.
- R6: Control bit 17 selects the request discipline. With the bit at 1, the peripheral request is checked before every beat. With the bit at 0, it is checked only before the first beat of each group of eight, counted from the start and from each reload.
- R7: Writing 1 to start bit 0 begins a transfer, and the bit reads 1 while the channel is busy. Without reload, the bit clears by itself once the count is done, and the remaining register then reads 0.
- R8: While the channel is busy, the remaining register shows the bytes not yet written.
- R9: `half_evt` pulses for one cycle on the cycle after the write acceptance that first brings the bytes moved to at least floor(count/2), for counts of 2 or more. `done_evt` pulses on the cycle after the final write acceptance of a pass.
- R10: Control bit 18 enables reload. At the end of each pass the channel reloads the programmed addresses and count and continues. The start bit stays 1, and both events are raised on every pass.
- R11: Writing 0 to the start bit stops the channel. A beat already in progress completes, no further beat starts, no done event is raised for the abandoned pass, and start and remaining both read 0.
- R12: The byte count is 19 bits wide, and count-register bits above bit 18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Master port request, held until accepted |
| mem_we | output | 1 | 1 for a write phase, 0 for a read phase |
| mem_addr | output | ADDR_W | Beat address |
| mem_bytes | output | 3 | Bytes carried by the current beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack in a read phase |
| mem_ack | input | 1 | Accepts the current phase |
| per_req | input | NSLOT | Peripheral request per slot |
| per_ack | output | NSLOT | One-cycle acknowledge per slot |
| half_evt | output | 1 | Half-pass event pulse |
| done_evt | output | 1 | Pass-complete event pulse |

## Verification
A read phase and a write phase each end on the clock edge at which `mem_ack` is high. The bench compares each accepted write at the falling edge of that same cycle. `per_ack` is combinational and is counted at the same falling edge. The two events are registered, so each is expected exactly one falling edge after the write acceptance that causes it; the monitor keeps the previous cycle's acceptance flag to check this. A start write shows on the register port one edge later. The engine loads the transfer one edge after that, so remaining-count reads are taken only several idle cycles after any change.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CNT_W  = 19;
  localparam int TYPE_W = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} eng_state_e;

  typedef struct packed {
    logic              reload;
    logic              single;
    logic              dst_fixed;
    logic              src_fixed;
    logic [1:0]        width;
    logic [TYPE_W-1:0] dst_type;
    logic [TYPE_W-1:0] src_type;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_ctl(input logic [31:0] c);
    chan_cfg_t r;
    r.src_type  = c[5:0];
    r.src_fixed = c[7];
    r.dst_type  = c[13:8];
    r.dst_fixed = c[15];
    r.single    = c[17];
    r.reload    = c[18];
    r.width     = c[21:20];
    return r;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [1:0] w, input logic [CNT_W-1:0] rem);
    logic [2:0] wb;
    wb = width_bytes(w);
    if (rem < CNT_W'(wb)) return rem[2:0];
    return wb;
  endfunction

  function automatic logic half_crossed(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] old_rem,
                                        input logic [CNT_W-1:0] new_rem);
    logic [CNT_W-1:0] thr, d_old, d_new;
    thr   = cnt >> 1;
    d_old = cnt - old_rem;
    d_new = cnt - new_rem;
    return (thr != '0) && (d_old < thr) && (d_new >= thr);
  endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       ctl_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start_q,
  input  logic              fin,
  input  logic              busy,
  input  logic [CNT_W-1:0]  rem
);
  logic wr_start;
  assign wr_start = reg_wr && (reg_addr == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (fin) start_q <= 1'b0;
      if (wr_start) start_q <= reg_wdata[0];
      if (reg_wr) begin
        case (reg_addr)
          3'd0: ctl_q <= reg_wdata;
          3'd2: src_q <= reg_wdata[ADDR_W-1:0];
          3'd3: dst_q <= reg_wdata[ADDR_W-1:0];
          3'd4: cnt_q <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ctl_q;
      3'd1:    reg_rdata = {31'b0, start_q};
      3'd2:    reg_rdata = 32'(src_q);
      3'd3:    reg_rdata = 32'(dst_q);
      3'd4:    reg_rdata = 32'(cnt_q);
      3'd5:    reg_rdata = busy ? 32'(rem) : 32'b0;
      default: reg_rdata = '0;
    endcase
  end

  // R7: a finish pulse from the engine drops the start bit unless software rewrites it
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !wr_start |=> !start_q);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NSLOT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctl_q,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              start_q,
  input  logic [NSLOT-1:0]  per_req,
  output logic [NSLOT-1:0]  per_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2:0]        mem_bytes,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              half_evt,
  output logic              done_evt,
  output logic              fin,
  output logic              busy,
  output logic [CNT_W-1:0]  rem
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  eng_state_e        st;
  chan_cfg_t         cfg_s;
  logic [ADDR_W-1:0] cur_src, cur_dst;
  logic [CNT_W-1:0]  rem_q, cnt_s, new_rem;
  logic [2:0]        grp, bb;
  logic [31:0]       data_q;
  logic              src_per, dst_per, need_req, src_ok, dst_ok;
  logic              beat_done, last_beat, load_now;

  function automatic logic slot_ready(input logic [TYPE_W-1:0] t, input logic [NSLOT-1:0] rq);
    if (int'(t) < NSLOT) return rq[t[SLOT_W-1:0]];
    return 1'b0;
  endfunction

  assign src_per   = cfg_s.src_type != '0;
  assign dst_per   = cfg_s.dst_type != '0;
  assign need_req  = cfg_s.single || (grp == 3'd0);
  assign src_ok    = !src_per || !need_req || slot_ready(cfg_s.src_type, per_req);
  assign dst_ok    = !dst_per || !need_req || slot_ready(cfg_s.dst_type, per_req);
  assign bb        = beat_bytes(cfg_s.width, rem_q);
  assign new_rem   = rem_q - CNT_W'(bb);
  assign beat_done = (st == ST_WR) && mem_ack;
  assign last_beat = new_rem == '0;
  assign load_now  = (st == ST_IDLE) && start_q && (cnt_q != '0);

  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = st == ST_WR;
  assign mem_addr  = (st == ST_WR) ? cur_dst : cur_src;
  assign mem_bytes = bb;
  assign mem_wdata = data_q;
  assign busy      = st != ST_IDLE;
  assign rem       = rem_q;
  assign fin       = ((st == ST_IDLE) && start_q && (cnt_q == '0)) ||
                     (beat_done && last_beat && !cfg_s.reload);

  for (genvar i = 0; i < NSLOT; i++) begin : g_ack
    assign per_ack[i] = beat_done &&
      ((src_per && (cfg_s.src_type == TYPE_W'(i))) || (dst_per && (cfg_s.dst_type == TYPE_W'(i))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cfg_s    <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      rem_q    <= '0;
      cnt_s    <= '0;
      grp      <= '0;
      data_q   <= '0;
      half_evt <= 1'b0;
      done_evt <= 1'b0;
    end else begin
      half_evt <= beat_done && half_crossed(cnt_s, rem_q, new_rem);
      done_evt <= beat_done && last_beat;
      case (st)
        ST_IDLE: if (load_now) begin
          cfg_s   <= decode_ctl(ctl_q);
          cur_src <= src_q;
          cur_dst <= dst_q;
          rem_q   <= cnt_q;
          cnt_s   <= cnt_q;
          grp     <= '0;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!start_q)           st <= ST_IDLE;
          else if (src_ok && dst_ok) st <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          if (!cfg_s.src_fixed) cur_src <= cur_src + ADDR_W'(bb);
          if (!cfg_s.dst_fixed) cur_dst <= cur_dst + ADDR_W'(bb);
          rem_q <= new_rem;
          grp   <= grp + 3'd1;
          if (last_beat) begin
            if (cfg_s.reload && start_q && (cnt_q != '0)) begin
              cfg_s   <= decode_ctl(ctl_q);
              cur_src <= src_q;
              cur_dst <= dst_q;
              rem_q   <= cnt_q;
              cnt_s   <= cnt_q;
              grp     <= '0;
              st      <= ST_WAIT;
            end else begin
              st <= ST_IDLE;
            end
          end else if (!start_q) begin
            st <= ST_IDLE;
          end else begin
            st <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a phase that is not accepted holds its request, address and direction
  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3: every beat carries at least one byte and never more than the width
  p_beat_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_bytes != 3'd0) && (mem_bytes <= width_bytes(cfg_s.width)));

  // R5: acknowledges are single-cycle pulses
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_ack) |=> (per_ack == '0));

  // R9: a pass-complete event always follows an accepted write
  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(mem_req && mem_we && mem_ack));

  // R9: a half event also follows an accepted write
  p_half_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NSLOT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2:0]        mem_bytes,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic [NSLOT-1:0]  per_req,
  output logic [NSLOT-1:0]  per_ack,
  output logic              half_evt,
  output logic              done_evt
);
  logic [31:0]       ctl_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, rem;
  logic              start_q, fin, busy;

  dmac_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_q(ctl_q),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .start_q(start_q),
    .fin(fin), .busy(busy), .rem(rem)
  );

  dmac_engine #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_engine (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .src_q(src_q), .dst_q(dst_q),
    .cnt_q(cnt_q), .start_q(start_q), .per_req(per_req), .per_ack(per_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_bytes(mem_bytes), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .half_evt(half_evt), .done_evt(done_evt),
    .fin(fin), .busy(busy), .rem(rem)
  );
endmodule

// File: tb/test_dmac_channel.sv
module test_dmac_channel;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0] mem_bytes;
  logic [NSLOT-1:0] per_req = '0;
  logic [NSLOT-1:0] per_ack;
  logic half_evt, done_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_channel i_dmac_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .per_req(per_req), .per_ack(per_ack), .half_evt(half_evt), .done_evt(done_evt)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h5A00_00A5;
  endfunction

  // memory model with periodic wait states
  logic [1:0] stall_ctr = '0;
  logic stall_en = 1'b0;
  always @(posedge clk) stall_ctr <= stall_ctr + 2'd1;
  assign mem_ack   = mem_req && !(stall_en && stall_ctr == 2'd3);
  assign mem_rdata = pat(mem_addr);

  typedef struct packed { logic [31:0] a; logic [31:0] d; logic [2:0] b; } exp_t;
  exp_t sb_q[$];

  int checks = 0, fails = 0;
  int wr_cnt = 0, half_cnt = 0, done_cnt = 0, half_at = 0;
  int ack_cnt [NSLOT];
  logic prev_wr = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes and checks event timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (half_evt) begin
        half_cnt++; half_at = wr_cnt;
        chk("R9 half follows write", 32'(prev_wr), 32'd1);
      end
      if (done_evt) begin
        done_cnt++;
        chk("R9 done follows write", 32'(prev_wr), 32'd1);
      end
      for (int i = 0; i < NSLOT; i++) if (per_ack[i]) ack_cnt[i]++;
      prev_wr = mem_req && mem_we && mem_ack;
      if (prev_wr) begin
        wr_cnt++;
        if (sb_q.size() == 0) chk("R2 unexpected write", mem_addr, 32'hFFFF_FFFF);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R4 write address", mem_addr, e.a);
          chk("R2 write data", mem_wdata, e.d);
          chk("R3 beat bytes", 32'(mem_bytes), 32'(e.b));
        end
      end
    end
  end

  // driver: restates the copy rules and queues the expected writes
  task automatic push_run(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                          input int w, input bit sfix, input bit dfix);
    int rem_b = cnt;
    int wb = (w == 0) ? 4 : (w == 1) ? 2 : 1;
    while (rem_b > 0) begin
      int b = (rem_b < wb) ? rem_b : wb;
      exp_t e;
      e.a = dst; e.d = pat(src); e.b = 3'(b);
      sb_q.push_back(e);
      if (!sfix) src += 32'(b);
      if (!dfix) dst += 32'(b);
      rem_b -= b;
    end
  endtask

  function automatic logic [31:0] mkctl(input int st, input bit sfix, input int dt, input bit dfix,
                                        input bit single, input bit reload, input int w);
    return 32'(st & 63) | (32'(sfix) << 7) | (32'(dt & 63) << 8) | (32'(dfix) << 15) |
           (32'(single) << 17) | (32'(reload) << 18) | (32'(w & 3) << 20);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (done_cnt < n && t < 2000) begin step(1); t++; end
  endtask

  task automatic wait_write_accept();
    do @(negedge clk); while (!(mem_req && mem_we && mem_ack));
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < NSLOT; i++) ack_cnt[i] = 0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(3'd1, v); chk("R1 start after reset", v, 0);
    rd(3'd5, v); chk("R1 remaining after reset", v, 0);
    chk("R1 no request", 32'(mem_req), 0);
    chk("R1 events low", 32'({half_evt, done_evt}), 0);

    // R2 R3 R7 R9: memory copy, 32-bit, with wait states
    stall_en = 1'b1;
    base = wr_cnt;
    push_run(32'h1000, 32'h2000, 16, 0, 0, 0);
    wr(3'd0, mkctl(0, 0, 0, 0, 1, 0, 0));
    wr(3'd2, 32'h1000); wr(3'd3, 32'h2000); wr(3'd4, 16);
    wr(3'd1, 1);
    wait_done(1); step(4);
    chk("R2 all writes seen", 32'(sb_q.size()), 0);
    chk("R9 one done", 32'(done_cnt), 1);
    chk("R9 one half", 32'(half_cnt), 1);
    chk("R9 half after second beat", 32'(half_at - base), 2);
    rd(3'd1, v); chk("R7 start self-clears", v, 0);
    rd(3'd5, v); chk("R7 remaining zero when idle", v, 0);

    // R3 R4: 8-bit, fixed source
    push_run(32'h3000, 32'h4000, 5, 2, 1, 0);
    wr(3'd0, mkctl(0, 1, 0, 0, 1, 0, 2));
    wr(3'd2, 32'h3000); wr(3'd3, 32'h4000); wr(3'd4, 5);
    wr(3'd1, 1);
    wait_done(2); step(4);
    chk("R4 fixed source run complete", 32'(sb_q.size()), 0);

    // R3 R4: 16-bit with short tail, fixed destination
    push_run(32'h5000, 32'h6000, 7, 1, 0, 1);
    wr(3'd0, mkctl(0, 0, 0, 1, 1, 0, 1));
    wr(3'd2, 32'h5000); wr(3'd3, 32'h6000); wr(3'd4, 7);
    wr(3'd1, 1);
    wait_done(3); step(4);
    chk("R3 tail run complete", 32'(sb_q.size()), 0);
    stall_en = 1'b0;

    // R5 R8 R12: peripheral source on slot 3, single mode, count written with high bits set
    base = wr_cnt;
    push_run(32'h0000_0300, 32'h7000, 16, 0, 1, 0);
    wr(3'd0, mkctl(3, 1, 0, 0, 1, 0, 0));
    wr(3'd2, 32'h0300); wr(3'd3, 32'h7000); wr(3'd4, 32'h0008_0010);
    wr(3'd1, 1);
    step(20);
    chk("R5 no beat without request", 32'(wr_cnt - base), 0);
    rd(3'd5, v); chk("R12 count truncated to 19 bits", v, 16);
    per_req[3] = 1'b1;
    wait_write_accept();
    per_req[3] = 1'b0;
    step(10);
    rd(3'd5, v); chk("R8 remaining mid-transfer", v, 12);
    chk("R5 single mode stalls after one beat", 32'(wr_cnt - base), 1);
    per_req[3] = 1'b1;
    wait_done(4); step(4);
    per_req[3] = 1'b0;
    chk("R5 one ack per beat", 32'(ack_cnt[3]), 4);
    chk("R5 run complete", 32'(sb_q.size()), 0);

    // R6: burst mode, request seen once per group of eight
    base = wr_cnt;
    push_run(32'h0300, 32'h7100, 10, 2, 1, 0);
    wr(3'd0, mkctl(3, 1, 0, 0, 0, 0, 2));
    wr(3'd2, 32'h0300); wr(3'd3, 32'h7100); wr(3'd4, 10);
    per_req[3] = 1'b1;
    wr(3'd1, 1);
    wait_write_accept();
    per_req[3] = 1'b0;
    step(60);
    chk("R6 group of eight runs without request", 32'(wr_cnt - base), 8);
    rd(3'd5, v); chk("R6 remaining after group", v, 2);
    per_req[3] = 1'b1;
    wait_done(5); step(4);
    per_req[3] = 1'b0;
    chk("R6 burst run complete", 32'(sb_q.size()), 0);

    // R11: stop mid-transfer, peripheral destination on slot 5
    base = wr_cnt;
    push_run(32'h8000, 32'h0500, 4, 0, 0, 1);
    wr(3'd0, mkctl(0, 0, 5, 1, 1, 0, 0));
    wr(3'd2, 32'h8000); wr(3'd3, 32'h0500); wr(3'd4, 16);
    per_req[5] = 1'b1;
    wr(3'd1, 1);
    wait_write_accept();
    per_req[5] = 1'b0;
    wr(3'd1, 0);
    step(10);
    per_req[5] = 1'b1;
    step(20);
    per_req[5] = 1'b0;
    chk("R11 no beat after stop", 32'(wr_cnt - base), 1);
    chk("R11 no done for abandoned pass", 32'(done_cnt), 5);
    rd(3'd1, v); chk("R11 start reads 0", v, 0);
    rd(3'd5, v); chk("R11 remaining reads 0", v, 0);
    chk("R5 destination acknowledged once", 32'(ack_cnt[5]), 1);

    // R10: reload loop, memory to memory
    base = wr_cnt;
    for (int r = 0; r < 5; r++) push_run(32'h9000, 32'hA000, 8, 0, 0, 0);
    wr(3'd0, mkctl(0, 0, 0, 0, 1, 1, 0));
    wr(3'd2, 32'h9000); wr(3'd3, 32'hA000); wr(3'd4, 8);
    begin
      int h0 = half_cnt;
      wr(3'd1, 1);
      wait_done(8);
      rd(3'd1, v); chk("R10 start stays set across passes", v, 1);
      chk("R10 half raised each pass", 32'(half_cnt - h0 >= 3), 1);
    end
    wr(3'd1, 0);
    step(20);
    chk("R10 at least three passes written", 32'(wr_cnt - base >= 6), 1);
    chk("R11 reload loop stopped", 32'(mem_req), 0);
    sb_q.delete();

    finish_up();
  end
endmodule